// File: doc/BRIEF.md
# Protected Eight-Channel Latched Driver Controller

This block is the digital control core of an eight-channel low-side driver with protection. Eight data bits are captured into per-channel latches while a load strobe is high, and a clear input empties all latches at once. Each latched bit drives one output. The output is on only when the shared enable allows it and no protection condition blocks that channel.

Each channel has its own over-current comparator input. That input must stay high for a programmable number of consecutive clock cycles before it counts as a fault. The default count gives 2 ms at 250 MHz. A filtered fault latches and turns off only that channel. It stays latched until the shared enable/reset pin sees a rising edge or the block is reset. An over-temperature input is not latched and turns every output off while it is active. A digital supply code is compared against two thresholds that form a hysteresis band. Low supply engages a lockout that forces every output off. An active-low fault flag is pulled low while any channel fault or the thermal fault is present.

Top module: `prot_drv_ctrl`

## Requirements
- R1: On a clock edge where `strobe` is high and `clear` is low, the channel latches take `din`. While both are low, the latches keep their value.
- R2: On a clock edge where `clear` is high, all latches become 0, whatever `strobe` is.
- R3: `drv_out[i]` is 1 only when all of the following hold: latch bit i is 1, `en_rst` is low (the enable is active-low), channel i has no latched fault, `therm_in` is low, and the lockout is released.
- R4: A channel fault latches on the clock edge at which `oc_in[i]` has been sampled high on `FILT_CYC` consecutive edges. A run of `FILT_CYC`-1 high samples followed by a low sample latches nothing, and the count restarts from zero.
- R5: A fault on one channel turns off only that channel's output. The other channels keep driving.
- R6: A latched fault holds after `oc_in` falls. It is cleared, together with its filter count, at the clock edge where `en_rst` is sampled high after being low on the previous edge, and that clear wins over a trip. Reset also clears it.
- R7: While `therm_in` is high, all outputs are 0. Once it falls, the outputs follow R3 again without any further action.
- R8: The lockout is engaged after reset. It releases on the edge at which `supply_code` >= `UV_ON`. Once released, it engages on the edge at which `supply_code` < `UV_OFF`. Between the two thresholds it keeps its state.
- R9: `flag_n` is 0 while any channel fault is latched or `therm_in` is high, and 1 otherwise.
- R10: During and right after reset, `drv_out` is 0 and `flag_n` is 1 when `therm_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | NCH | Parallel channel data |
| strobe | input | 1 | Latch load (transparent while high) |
| clear | input | 1 | Clear all latches, priority over strobe |
| en_rst | input | 1 | Active-low output enable; a rising edge clears channel faults |
| oc_in | input | NCH | Per-channel over-current comparator outputs |
| therm_in | input | 1 | Over-temperature indication |
| supply_code | input | SUP_W | Digitized supply voltage |
| drv_out | output | NCH | Per-channel drive bits |
| flag_n | output | 1 | Active-low fault flag |

## Verification
The hardest case to reach is the filter boundary. A channel's comparator input must stay high for exactly `FILT_CYC` or exactly one cycle fewer, with no enable/reset edge in between. Directed runs of 15 and 16 cycles at a filter length of 16 hit this case. The random phase holds each `oc_in` bit sticky, flipping it rarely, so long runs occur on several channels at once. The supply code follows a random walk across both thresholds, which visits the hysteresis band from both directions.

// File: rtl/prot_drv_pkg.sv
package prot_drv_pkg;
  typedef enum logic {
    UV_RUN  = 1'b0,
    UV_LOCK = 1'b1
  } uv_state_t;

  function automatic int cnt_width(input int cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction
endpackage

// File: rtl/drv_latch_bank.sv
module drv_latch_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic           strobe,
  input  logic           clear,
  output logic [NCH-1:0] q
);
  logic [NCH-1:0] q_r;
  logic [NCH-1:0] q_nx;
  logic           ld_en;

  assign ld_en = clear | strobe;

  always_comb begin
    q_nx = q_r;
    if (clear)       q_nx = '0;
    else if (strobe) q_nx = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (ld_en) q_r <= q_nx;
  end

  assign q = q_r;

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == '0));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !strobe) |=> $stable(q));
endmodule

// File: rtl/oc_fault_chan.sv
module oc_fault_chan #(
  parameter int FILT_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_in,
  input  logic clr,
  output logic fault
);
  localparam int CNT_W = prot_drv_pkg::cnt_width(FILT_CYC);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt_r, cnt_nx;
  logic             fault_r, fault_nx;

  always_comb begin
    cnt_nx   = cnt_r;
    fault_nx = fault_r;
    if (clr) begin
      cnt_nx   = '0;
      fault_nx = 1'b0;
    end else if (fault_r || !oc_in) begin
      cnt_nx = '0;
    end else if (cnt_r == LIM) begin
      cnt_nx   = '0;
      fault_nx = 1'b1;
    end else begin
      cnt_nx = cnt_r + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r   <= '0;
      fault_r <= 1'b0;
    end else begin
      cnt_r   <= cnt_nx;
      fault_r <= fault_nx;
    end
  end

  assign fault = fault_r;

  assert_trip_needs_oc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(oc_in));
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> fault);
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fault);
endmodule

// File: rtl/uvlo_hyst.sv
module uvlo_hyst #(
  parameter int SUP_W  = 8,
  parameter int UV_OFF = 100,
  parameter int UV_ON  = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_code,
  output logic             locked
);
  import prot_drv_pkg::*;

  localparam logic [SUP_W-1:0] TH_OFF = SUP_W'(UV_OFF);
  localparam logic [SUP_W-1:0] TH_ON  = SUP_W'(UV_ON);

  uv_state_t st_r, st_nx;

  always_comb begin
    st_nx = st_r;
    case (st_r)
      UV_LOCK: if (supply_code >= TH_ON)  st_nx = UV_RUN;
      default: if (supply_code <  TH_OFF) st_nx = UV_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_r <= UV_LOCK;
    else        st_r <= st_nx;
  end

  assign locked = (st_r == UV_LOCK);

  assert_stay_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && supply_code < TH_ON) |=> locked);
  assert_stay_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && supply_code >= TH_OFF) |=> !locked);
endmodule

// File: rtl/prot_drv_ctrl.sv
module prot_drv_ctrl #(
  parameter int NCH      = 8,
  parameter int FILT_CYC = 500000,
  parameter int SUP_W    = 8,
  parameter int UV_OFF   = 100,
  parameter int UV_ON    = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   din,
  input  logic             strobe,
  input  logic             clear,
  input  logic             en_rst,
  input  logic [NCH-1:0]   oc_in,
  input  logic             therm_in,
  input  logic [SUP_W-1:0] supply_code,
  output logic [NCH-1:0]   drv_out,
  output logic             flag_n
);
  logic [1:0]     rst_sync;
  logic           core_rst_n;
  logic           en_q;
  logic           fault_clr;
  logic [NCH-1:0] latch_q;
  logic [NCH-1:0] fault_v;
  logic           locked;
  logic           gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) en_q <= 1'b0;
    else             en_q <= en_rst;
  end
  assign fault_clr = en_rst & ~en_q;

  drv_latch_bank #(.NCH(NCH)) u_latch (
    .clk(clk), .rst_n(core_rst_n), .din(din),
    .strobe(strobe), .clear(clear), .q(latch_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    oc_fault_chan #(.FILT_CYC(FILT_CYC)) u_oc (
      .clk(clk), .rst_n(core_rst_n), .oc_in(oc_in[i]),
      .clr(fault_clr), .fault(fault_v[i])
    );
  end

  uvlo_hyst #(.SUP_W(SUP_W), .UV_OFF(UV_OFF), .UV_ON(UV_ON)) u_uvlo (
    .clk(clk), .rst_n(core_rst_n), .supply_code(supply_code), .locked(locked)
  );

  assign gate_ok = ~en_rst & ~therm_in & ~locked;
  assign drv_out = latch_q & ~fault_v & {NCH{gate_ok}};
  assign flag_n  = ~((|fault_v) | therm_in);

  assert_therm_off_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    therm_in |-> (drv_out == '0));
  assert_fault_chan_off_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((drv_out & fault_v) == '0));
  assert_flag_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fault_v != '0) |-> !flag_n);
endmodule

// File: tb/prot_drv_ctrl_bench.sv
module prot_drv_ctrl_bench;
  localparam int NCH = 8, FILT = 16, SW = 8, UOFF = 100, UON = 120;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] din, oc_in, drv_out;
  logic strobe, clear, en_rst, therm_in, flag_n;
  logic [SW-1:0] supply_code;

  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;

  logic [NCH-1:0] m_latch, m_fault;
  int             m_cnt [NCH];
  logic           m_lock, m_enq;

  always #2 clk = ~clk;

  prot_drv_ctrl #(.NCH(NCH), .FILT_CYC(FILT), .SUP_W(SW), .UV_OFF(UOFF), .UV_ON(UON))
    u_prot_drv_ctrl (.clk(clk), .rst_n(rst_n), .din(din), .strobe(strobe),
      .clear(clear), .en_rst(en_rst), .oc_in(oc_in), .therm_in(therm_in),
      .supply_code(supply_code), .drv_out(drv_out), .flag_n(flag_n));

  function automatic logic [NCH-1:0] exp_out();
    if (en_rst || therm_in || m_lock) return '0;
    return m_latch & ~m_fault;
  endfunction

  function automatic logic exp_flag();
    return !((m_fault != '0) || therm_in);
  endfunction

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic rise;
    rise = en_rst && !m_enq;
    for (int i = 0; i < NCH; i++) begin
      if (rise) begin m_fault[i] = 1'b0; m_cnt[i] = 0; end
      else if (m_fault[i] || !oc_in[i]) m_cnt[i] = 0;
      else if (m_cnt[i] == FILT - 1) begin m_fault[i] = 1'b1; m_cnt[i] = 0; end
      else m_cnt[i]++;
    end
    m_enq = en_rst;
    if (clear) m_latch = '0;
    else if (strobe) m_latch = din;
    if (m_lock && supply_code >= SW'(UON)) m_lock = 1'b0;
    else if (!m_lock && supply_code < SW'(UOFF)) m_lock = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    chk("R3 drive gating", drv_out, exp_out());
    chk("R9 flag", {{(NCH-1){1'b0}}, flag_n}, {{(NCH-1){1'b0}}, exp_flag()});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1'b1;
  end

  initial begin
    int seed;
    logic [NCH-1:0] keep;
    seed = $urandom(7);
    rst_n = 1'b0; din = '0; oc_in = '0; strobe = 0; clear = 0; en_rst = 0;
    therm_in = 0; supply_code = '0;
    m_latch = '0; m_fault = '0; m_lock = 1'b1; m_enq = 1'b0;
    for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset drv", drv_out, '0);
    chk("R10 reset flag", {7'd0, flag_n}, 8'd1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 post-reset drv", drv_out, '0);

    // R8 release and R1 load
    supply_code = 8'd200; tick();
    din = 8'hA5; strobe = 1; tick();
    chk("R1 load", drv_out, 8'hA5);
    strobe = 0; din = 8'h3C; ticks(2);
    chk("R1 hold", drv_out, 8'hA5);
    // R2 clear priority
    clear = 1; strobe = 1; din = 8'hFF; tick();
    chk("R2 clear wins", drv_out, 8'h00);
    clear = 0; tick();
    strobe = 0; tick();
    chk("R1 reload", drv_out, 8'hFF);
    // R4 short pulse
    oc_in = 8'h04; ticks(FILT - 1);
    oc_in = 8'h00; tick();
    chk("R4 short pulse no trip", drv_out, 8'hFF);
    oc_in = 8'h04; ticks(FILT - 1);
    chk("R4 before boundary", drv_out, 8'hFF);
    tick();
    chk("R4 trip at boundary", drv_out, 8'hFB);
    chk("R5 others keep driving", drv_out & 8'hFB, 8'hFB);
    chk("R9 flag low on fault", {7'd0, flag_n}, 8'd0);
    oc_in = 8'h00; ticks(3);
    chk("R6 fault holds", drv_out, 8'hFB);
    en_rst = 1; tick();
    chk("R3 enable high off", drv_out, 8'h00);
    en_rst = 0; tick();
    chk("R6 cleared by pulse", drv_out, 8'hFF);
    // R7 thermal
    therm_in = 1; #1;
    chk("R7 thermal off", drv_out, 8'h00);
    tick();
    therm_in = 0; #1;
    chk("R7 thermal returns", drv_out, 8'hFF);
    // R8 hysteresis
    supply_code = 8'd110; ticks(2);
    chk("R8 band keeps run", drv_out, 8'hFF);
    supply_code = 8'd99; tick();
    chk("R8 lockout engages", drv_out, 8'h00);
    supply_code = 8'd119; ticks(2);
    chk("R8 band keeps lock", drv_out, 8'h00);
    supply_code = 8'd120; tick();
    chk("R8 release", drv_out, 8'hFF);

    // random phase
    keep = '0;
    for (int c = 0; c < 4000; c++) begin
      din = 8'($urandom);
      strobe = ($urandom % 4) == 0;
      clear = ($urandom % 40) == 0;
      en_rst = ($urandom % 60) == 0;
      therm_in = ($urandom % 50) == 0;
      for (int i = 0; i < NCH; i++)
        if (($urandom % 24) == 0) keep[i] = ~keep[i];
      oc_in = keep;
      if ($urandom % 2) supply_code = (supply_code > 8'd195) ? 8'd200 : supply_code + 8'd5;
      else supply_code = (supply_code < 8'd65) ? 8'd60 : supply_code - 8'd5;
      tick();
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule